// File: doc/BRIEF.md
# Layered Neuron Tile Grid

The block evaluates a small fully connected network in signed fixed-point arithmetic. The network is laid out in space as a grid of compute tiles. Each row of the grid is one network layer, and each tile in a row is one neuron of that layer. A vector presented at the input is taken by the top row. Every tile of that row multiplies the whole vector, one element per clock, against the weight vector that tile holds, and accumulates the result. The finished row assembles the results of its tiles into a vector and hands it to the row beneath. The vector assembled by the bottom row is the network output and is flagged by a one-cycle valid pulse.

Weights sit in registers inside each tile. They are written through a port addressed by layer, neuron and input element. This is allowed only while the grid is idle, and while a vector is in flight the grid accepts neither writes nor new input vectors. Operands and results are signed Q8.8 values. Each tile accumulates in a 32-bit register that saturates instead of wrapping. At the end of the dot product the accumulator is shifted down to Q8.8 and clamped to that range.

Top module: `nn_tile_grid`

## Requirements
- R1: After reset, out_valid and busy are 0 and out_vec is all zeros.
- R2: Each neuron's result is the dot product of its incoming vector with its weights, using signed Q8.8 operands (16 bits, 8 fraction bits). The products are added in input-element order, 0 first.
- R3: Each addition into the 32-bit accumulator saturates to the signed 32-bit range (0x7FFFFFFF / 0x80000000) instead of wrapping.
- R4: The final accumulator is shifted right arithmetically by 8 bits, which truncates toward minus infinity. It is then clamped to the range 0x8000..0x7FFF before it is output.
- R5: Row 0 (top) takes the input vector. Row r+1 takes the vector assembled by row r. out_vec is the vector assembled by the bottom row.
- R6: out_valid rises exactly ROWS*(COLS+1)-1 clock edges after the edge that accepts in_valid. That is 19 edges for the default 4x4 grid.
- R7: out_valid is high for exactly one cycle per accepted vector.
- R8: busy is 1 from the cycle after an accepted in_valid until the cycle out_valid is high, and 0 the cycle after. An in_valid that arrives while busy is 1 is ignored: it produces no result and no extra out_valid.
- R9: A weight write (w_we) that arrives while busy is 1 is discarded. The stored weight keeps its old value.
- R10: A weight write stores w_data as the weight that layer w_row (0 = top), neuron w_col applies to input element w_idx. Neuron w_col drives output element w_col of its row.
- R11: Element j of in_vec and of out_vec occupies bits [16*j+15 : 16*j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Presents in_vec; accepted when busy is 0 |
| in_vec | input | COLS*DW | Input vector, Q8.8 elements |
| w_we | input | 1 | Weight write strobe, honoured only when idle |
| w_row | input | RW | Layer index of the weight |
| w_col | input | CW | Neuron index of the weight |
| w_idx | input | CW | Input element index of the weight |
| w_data | input | DW | Weight value, Q8.8 |
| busy | output | 1 | A vector is in flight |
| out_valid | output | 1 | One-cycle pulse, out_vec holds the network output |
| out_vec | output | COLS*DW | Output vector of the bottom row, Q8.8 elements |

## Verification
The hardest conditions to reach from the ports are accumulator saturation part-way through a dot product and stimulus arriving mid-flight. Random weights and inputs almost never drive a partial sum past the 32-bit range. The bench therefore uses directed full-scale weights and inputs: four maximum-magnitude products overflow the accumulator, so a wrapping design gives a visibly different result from a saturating one. The mid-flight runs inject a second input vector and a weight write a few cycles after acceptance. The bench then confirms that the output and the next result still reflect the state from before the injection.

// File: rtl/nn_grid_pkg.sv
package nn_grid_pkg;

    // Row sequencing state
    typedef enum logic {
        ROW_IDLE = 1'b0,
        ROW_RUN  = 1'b1
    } row_state_e;

endpackage

// File: rtl/nn_mac_tile.sv
module nn_mac_tile #(
    parameter int N    = 4,
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int AW   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  busy_i,
    input  logic                  we_i,
    input  logic [CW-1:0]         widx_i,
    input  logic [DW-1:0]         wdata_i,
    input  logic                  mac_en_i,
    input  logic                  first_i,
    input  logic                  last_i,
    input  logic [CW-1:0]         ridx_i,
    input  logic [DW-1:0]         x_i,
    output logic [DW-1:0]         res_o
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic signed [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};
    localparam logic signed [AW-1:0] RES_MAX = AW'((64'sd1 <<< (DW-1)) - 64'sd1);
    localparam logic signed [AW-1:0] RES_MIN = -RES_MAX - AW'(1);

    typedef struct packed {
        logic [N-1:0][DW-1:0]   w;
        logic signed [AW-1:0]   acc;
        logic [DW-1:0]          res;
    } tile_t;

    tile_t st_d, st_q;

    logic signed [DW-1:0] wa, xb;
    logic signed [AW-1:0] prod, base, acc_nx, shifted;
    logic signed [AW:0]   sum_w;

    always_comb begin
        st_d    = st_q;
        wa      = st_q.w[ridx_i];
        xb      = x_i;
        prod    = AW'(wa) * AW'(xb);
        base    = first_i ? '0 : st_q.acc;
        sum_w   = {base[AW-1], base} + {prod[AW-1], prod};
        if (sum_w[AW] != sum_w[AW-1]) begin
            acc_nx = sum_w[AW] ? ACC_MIN : ACC_MAX;
        end else begin
            acc_nx = sum_w[AW-1:0];
        end
        shifted = acc_nx >>> FRAC;

        if (we_i) begin
            st_d.w[widx_i] = wdata_i;
        end
        if (mac_en_i) begin
            st_d.acc = acc_nx;
            if (last_i) begin
                if (shifted > RES_MAX) begin
                    st_d.res = RES_MAX[DW-1:0];
                end else if (shifted < RES_MIN) begin
                    st_d.res = RES_MIN[DW-1:0];
                end else begin
                    st_d.res = shifted[DW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;

    // R9: weights stay frozen while a vector is in flight
    a_r9_weights_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> st_q.w == $past(st_q.w));

    // R3: a non-negative partial sum plus a non-negative product never turns negative
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en_i && !first_i && !st_q.acc[AW-1] && !prod[AW-1]) |=> !st_q.acc[AW-1]);

endmodule

// File: rtl/nn_layer_row.sv
module nn_layer_row
    import nn_grid_pkg::*;
#(
    parameter int N    = 4,
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int AW   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [N-1:0][DW-1:0]  vec_i,
    input  logic                  busy_i,
    input  logic                  we_i,
    input  logic [CW-1:0]         wcol_i,
    input  logic [CW-1:0]         widx_i,
    input  logic [DW-1:0]         wdata_i,
    output logic                  active_o,
    output logic                  done_o,
    output logic [N-1:0][DW-1:0]  vec_o
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        row_state_e           st;
        logic [CW-1:0]        cnt;
        logic [N-1:0][DW-1:0] vec;
        logic                 done;
    } row_t;

    row_t rs_d, rs_q;

    logic mac_en, first, last;

    always_comb begin
        rs_d      = rs_q;
        rs_d.done = 1'b0;
        case (rs_q.st)
            ROW_IDLE: begin
                if (start_i) begin
                    rs_d.st  = ROW_RUN;
                    rs_d.cnt = '0;
                    rs_d.vec = vec_i;
                end
            end
            default: begin
                if (rs_q.cnt == LAST) begin
                    rs_d.st   = ROW_IDLE;
                    rs_d.done = 1'b1;
                    rs_d.cnt  = '0;
                end else begin
                    rs_d.cnt = rs_q.cnt + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '{st: ROW_IDLE, default: '0};
        end else begin
            rs_q <= rs_d;
        end
    end

    assign mac_en   = (rs_q.st == ROW_RUN);
    assign first    = (rs_q.cnt == '0);
    assign last     = (rs_q.cnt == LAST);
    assign active_o = mac_en | rs_q.done;
    assign done_o   = rs_q.done;

    for (genvar j = 0; j < N; j++) begin : g_tile
        nn_mac_tile #(.N(N), .DW(DW), .FRAC(FRAC), .AW(AW)) u_tile (
            .clk      (clk),
            .rst_n    (rst_n),
            .busy_i   (busy_i),
            .we_i     (we_i && (wcol_i == CW'(j))),
            .widx_i   (widx_i),
            .wdata_i  (wdata_i),
            .mac_en_i (mac_en),
            .first_i  (first),
            .last_i   (last),
            .ridx_i   (rs_q.cnt),
            .x_i      (rs_q.vec[rs_q.cnt]),
            .res_o    (vec_o[j])
        );
    end

    // R5: a row is only started when it has finished its previous vector
    a_r5_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> rs_q.st == ROW_IDLE);

    // R6: completion follows the final element of a run
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        rs_q.done |-> ($past(rs_q.st) == ROW_RUN && $past(rs_q.cnt) == LAST));

    // R7: the row completion flag is a single-cycle pulse
    a_r7_row_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rs_q.done |=> !rs_q.done);

endmodule

// File: rtl/nn_tile_grid.sv
module nn_tile_grid #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int AW   = 32,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [COLS*DW-1:0]   in_vec,
    input  logic                 w_we,
    input  logic [RW-1:0]        w_row,
    input  logic [CW-1:0]        w_col,
    input  logic [CW-1:0]        w_idx,
    input  logic [DW-1:0]        w_data,
    output logic                 busy,
    output logic                 out_valid,
    output logic [COLS*DW-1:0]   out_vec
);
    localparam int LAT   = ROWS * (COLS + 1) - 1;
    localparam int LCW   = $clog2(LAT + 2);

    logic [COLS-1:0][DW-1:0] link   [ROWS+1];
    logic [ROWS:0]           start;
    logic [ROWS-1:0]         active;
    logic [ROWS-1:0]         done;
    logic                    accept;
    logic                    wr_ok;

    assign accept   = in_valid && !busy;
    assign wr_ok    = w_we && !busy;
    assign busy     = |active;
    assign link[0]  = in_vec;
    assign start[0] = accept;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        nn_layer_row #(.N(COLS), .DW(DW), .FRAC(FRAC), .AW(AW)) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start[r]),
            .vec_i    (link[r]),
            .busy_i   (busy),
            .we_i     (wr_ok && (w_row == RW'(r))),
            .wcol_i   (w_col),
            .widx_i   (w_idx),
            .wdata_i  (w_data),
            .active_o (active[r]),
            .done_o   (done[r]),
            .vec_o    (link[r+1])
        );
        assign start[r+1] = done[r];
    end

    assign out_valid = done[ROWS-1];
    assign out_vec   = link[ROWS];

    // Cycle counter used only by the latency property
    logic [LCW-1:0] lat_d, lat_q;
    always_comb begin
        lat_d = lat_q;
        if (accept) begin
            lat_d = '0;
        end else if (busy && lat_q != LCW'(LAT + 1)) begin
            lat_d = lat_q + LCW'(1);
        end
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    // R6: output appears exactly LAT edges after acceptance
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> lat_q == LCW'(LAT));

    // R7: one-cycle output pulse
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: acceptance makes the grid busy, completion releases it
    a_r8_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy);
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !busy);

endmodule

// File: tb/tb_nn_tile_grid.sv
module tb_nn_tile_grid;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int DW   = 16;
    localparam int LAT  = ROWS * (COLS + 1) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [COLS*DW-1:0]  in_vec = '0;
    logic                w_we = 1'b0;
    logic [1:0]          w_row = '0;
    logic [1:0]          w_col = '0;
    logic [1:0]          w_idx = '0;
    logic [DW-1:0]       w_data = '0;
    logic                busy, out_valid;
    logic [COLS*DW-1:0]  out_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int unsigned seed_v;

    int wm [ROWS][COLS][COLS];

    nn_tile_grid #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .w_we(w_we), .w_row(w_row), .w_col(w_col), .w_idx(w_idx), .w_data(w_data),
        .busy(busy), .out_valid(out_valid), .out_vec(out_vec)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint sx16(input int v);
        return longint'(shortint'(v[15:0]));
    endfunction

    // Golden model built from R2..R5
    function automatic logic [COLS*DW-1:0] model(input logic [COLS*DW-1:0] v);
        logic [COLS*DW-1:0] cur, nxt;
        cur = v;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                longint acc, res;
                acc = 0;
                for (int k = 0; k < COLS; k++) begin
                    acc = acc + sx16(wm[r][c][k]) * sx16(int'(cur[k*DW +: DW]));
                    if (acc > 64'sd2147483647) acc = 64'sd2147483647;
                    if (acc < -64'sd2147483648) acc = -64'sd2147483648;
                end
                res = acc >>> 8;
                if (res > 32767) res = 32767;
                if (res < -32768) res = -32768;
                nxt[c*DW +: DW] = res[15:0];
            end
            cur = nxt;
        end
        return cur;
    endfunction

    task automatic wr(input int r, input int c, input int k, input int val, input bit keep);
        @(negedge clk);
        w_we = 1'b1; w_row = 2'(r); w_col = 2'(c); w_idx = 2'(k); w_data = val[15:0];
        @(negedge clk);
        w_we = 1'b0;
        if (keep) wm[r][c][k] = val & 16'hFFFF;
    endtask

    task automatic load_random(input int span);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                for (int k = 0; k < COLS; k++) begin
                    int v;
                    v = int'($urandom_range(2 * span)) - span;
                    wr(r, c, k, v, 1'b1);
                end
    endtask

    task automatic load_const(input int val);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                for (int k = 0; k < COLS; k++) wr(r, c, k, val, 1'b1);
    endtask

    // mode: 0 plain, 1 inject second vector while busy, 2 inject weight write while busy
    task automatic run(input logic [COLS*DW-1:0] v, input int mode, input string req);
        logic [COLS*DW-1:0] exp;
        int lat;
        exp = model(v);
        @(negedge clk);
        in_valid = 1'b1; in_vec = v;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        check(busy == 1'b1, "R8 busy after accept", longint'(busy), 1);
        while (!out_valid && lat < LAT + 10) begin
            if (lat == 3 && mode == 1) begin
                in_valid = 1'b1; in_vec = ~v;
            end else if (lat == 3 && mode == 2) begin
                w_we = 1'b1; w_row = 2'd0; w_col = 2'd0; w_idx = 2'd0;
                w_data = 16'(wm[0][0][0] ^ 16'h1234);
            end
            @(negedge clk);
            in_valid = 1'b0; w_we = 1'b0;
            lat++;
        end
        check(lat == LAT, "R6 latency", lat, LAT);
        check(out_vec == exp, req, out_vec, exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 single pulse", out_valid, 0);
        check(busy == 1'b0, "R8 busy release", busy, 0);
        if (mode == 1) begin
            bit extra;
            extra = 0;
            for (int i = 0; i < LAT + 5; i++) begin
                @(negedge clk);
                if (out_valid || busy) extra = 1;
            end
            check(!extra, "R8 in_valid while busy ignored", extra, 0);
        end
    endtask

    function automatic logic [COLS*DW-1:0] rand_vec(input int span);
        logic [COLS*DW-1:0] v;
        for (int k = 0; k < COLS; k++) begin
            int e;
            e = int'($urandom_range(2 * span)) - span;
            v[k*DW +: DW] = e[15:0];
        end
        return v;
    endfunction

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [COLS*DW-1:0] v;
        seed_v = $urandom(32'h5EED_0042);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                for (int k = 0; k < COLS; k++) wm[r][c][k] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid reset", out_valid, 0);
        check(busy == 1'b0, "R1 busy reset", busy, 0);
        check(out_vec == '0, "R1 out_vec reset", out_vec, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R11: identity on lower layers, rotation on row 0
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                for (int k = 0; k < COLS; k++) begin
                    bit hit;
                    hit = (r == 0) ? (k == (c + 1) % COLS) : (k == c);
                    wr(r, c, k, hit ? 32'h0100 : 0, 1'b1);
                end
        v = {16'h0400, 16'hFE80, 16'h0123, 16'h7000};
        run(v, 0, "R10 R11 addressing");
        check(out_vec[15:0] == 16'h0123, "R10 element 0 from input 1", out_vec[15:0], 16'h0123);

        // R2 / R5: constrained random small values
        for (int n = 0; n < 6; n++) begin
            load_random(180);
            for (int m = 0; m < 5; m++) run(rand_vec(600), 0, "R2 R5 random dot products");
        end
        // R4: larger values that reach the Q8.8 clamp
        load_random(2000);
        for (int m = 0; m < 5; m++) run(rand_vec(20000), 0, "R4 output clamp random");
        load_const(32'h0400);
        run({4{16'h4000}}, 0, "R4 positive clamp");
        run({4{16'hC000}}, 0, "R4 negative clamp");

        // R3: accumulator saturation
        load_const(32'h7FFF);
        run({4{16'h7FFF}}, 0, "R3 positive accumulator saturation");
        check(out_vec[15:0] == 16'h7FFF, "R3 positive saturated value", out_vec[15:0], 16'h7FFF);
        load_const(32'h8000);
        run({4{16'h7FFF}}, 0, "R3 negative accumulator saturation");

        // R8: second vector while busy ignored
        load_random(180);
        run(rand_vec(600), 1, "R8 result with injected vector");
        // R9: weight write during busy discarded
        v = rand_vec(600);
        run(v, 2, "R9 result with injected write");
        run(v, 0, "R9 old weights kept");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule